// File: doc/BRIEF.md
# Character Display Row Serializer

This block builds the picture of a character-mode dot-matrix display one common line (one pixel row) at a time. For each character cell of the current text line it reads the character code from display data memory. It then fetches the matching five-dot row slice, either from a writable character-generator RAM (user glyphs) or from a fixed character ROM. All three memories sit outside the block and are reached through read ports with one cycle of latency. The block overlays the underline cursor and the blink effect on the cell addressed by the address counter. It shifts the dots serially into a segment shift register and transfers the full row to the 40 segment outputs in one step. It also walks the 16 common outputs through the rows of the selected font and line mode.

Display-side reads are only issued in cycles where the host owns no memory access, so host writes never disturb the row being built. The block has no handshake at its edges: memory read requests are single-cycle strobes, and the segment and common outputs hold their values between row latches. Font height and line mode are sampled once per frame. The cursor and blink controls are used live.

Top module: `crow_row_serializer`

## Requirements
- R1: While reset is asserted, all segment outputs, all common outputs, `latch_stb` and `frame_start` are 0, and the blink frame counter restarts at zero.
- R2: For every row, character positions are fetched and shifted from the highest position (start address + 7) down to position 0 (start address). After the latch, `seg_out[5*p+d]` holds dot column d (0 = leftmost, taken from pattern bit 4-d) of position p. The start address is 0x00 for text line 0 and 0x40 for text line 1.
- R3: The segment outputs change only in the cycle where `latch_stb` is high. That happens once the position-0 character has fully entered the shift register, and the latched value is the complete row.
- R4: A code whose bits 7..4 are all zero takes its row from the character RAM at `cg_addr = {sel[2:0], row[3:0]}`. Any other code takes it from the ROM at `rom_addr = {code[7:0], row[3:0]}`.
- R5: In short-font mode, sel = code[2:0], so code bit 3 is ignored. In tall-font mode, sel = {0, code[2:1]}, so codes 00h, 01h, 08h and 09h show the same glyph.
- R6: In tall-font mode the character RAM row 10 (the 11th line) is ORed into the displayed row as is. Any set bit in it lights that dot whatever the cursor position.
- R7: When `cursor_en` is 1, the cell whose display address equals `ac` has all five dots on in its last row (row 7 for the short font, row 10 for the tall font).
- R8: When `blink_en` is 1, the cell at `ac` shows all dots on in every row during frames in which bit BLINK_LOG2 of the frame count (frames since reset) is 1. In the other frames it shows its normal pattern.
- R9: `com_out` is one-hot after each latch, with bit c set for common line c. Common c shows row c in tall-font mode (11 active commons, one text line). In short-font mode it shows row c mod 8 of text line c/8 (8 active commons, or 16 when `two_line` is 1).
- R10: After the last active common, the sequence wraps to common 0. `frame_start` pulses together with `latch_stb` on the latch of the last active common, and at no other time.
- R11: No display read strobe (`dd_rd`, `cg_rd`, `rom_rd`) is high in a cycle where `host_slot` is high. Read data is taken one cycle after its strobe.
- R12: `tall_font` and `two_line` are sampled only at the start of common 0. A change in mid-frame takes effect from the next frame.
- R13: `cg_rd` and `rom_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_slot | input | 1 | Host owns the memories this cycle; display reads wait |
| tall_font | input | 1 | 1 = 11-row cells, one text line |
| two_line | input | 1 | 1 = two text lines in short-font mode |
| cursor_en | input | 1 | Underline cursor enable |
| blink_en | input | 1 | Blink enable for the cursor cell |
| ac | input | 7 | Address counter; cursor and blink cell |
| dd_rd | output | 1 | Display data memory read strobe |
| dd_addr | output | 7 | Display data memory address |
| dd_data | input | 8 | Character code, valid one cycle after `dd_rd` |
| cg_rd | output | 1 | Character RAM read strobe |
| cg_addr | output | 7 | Character RAM address {sel, row} |
| cg_data | input | 5 | Character RAM row, valid one cycle after `cg_rd` |
| rom_rd | output | 1 | Character ROM read strobe |
| rom_addr | output | 12 | Character ROM address {code, row} |
| rom_data | input | 5 | Character ROM row, valid one cycle after `rom_rd` |
| seg_out | output | 40 | Latched segment row |
| com_out | output | 16 | Common selection, one-hot after the first latch |
| latch_stb | output | 1 | High in the cycle new segment and common values appear |
| frame_start | output | 1 | Pulses with the latch of the last active common |

## Verification
The assertions check on every cycle the rules that need no knowledge of memory contents. No read strobe is raised in a host cycle, and the two pattern ports are never strobed together. The common outputs stay one-hot and, like the segments, change only on a latch. `frame_start` only comes with a latch, and character RAM row addresses stay below 11. The bench scenarios alone can show that the latched dots are right. That covers the reversed fetch order, the RAM/ROM choice, code aliasing, the row-10 OR term, cursor placement, blink phases over several frames, the active common count per mode and the once-per-frame sampling of the mode inputs.

// File: rtl/crow_pkg.sv
package crow_pkg;
  localparam int SHORT_ROWS = 8;
  localparam int TALL_ROWS  = 11;
  localparam int SROW_W     = $clog2(SHORT_ROWS);

  typedef struct packed {
    logic tall;
    logic two;
  } mode_t;

  typedef enum logic [2:0] {
    ST_ROW,
    ST_DD_REQ,
    ST_DD_WAIT,
    ST_PAT_REQ,
    ST_PAT_WAIT,
    ST_SHIFT,
    ST_LATCH
  } fetch_st_e;
endpackage

// File: rtl/crow_seq.sv
// Common-line and frame sequencer: picks the row being built, owns the
// per-frame mode sample, the common outputs and the blink frame counter.
module crow_seq
  import crow_pkg::*;
#(
  parameter int NCOM       = 16,
  parameter int ROW_W      = 4,
  parameter int BLINK_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             row_done,
  input  logic             tall_i,
  input  logic             two_i,
  output mode_t            mode,
  output logic [ROW_W-1:0] cell_row,
  output logic             line_sel,
  output logic             last_row,
  output logic [NCOM-1:0]  com_out,
  output logic             frame_start,
  output logic             blink_phase
);
  localparam int CIDX_W = $clog2(NCOM);
  localparam int FCNT_W = BLINK_LOG2 + 1;

  logic [CIDX_W-1:0] com_idx;
  logic [CIDX_W-1:0] last_com;
  logic [FCNT_W-1:0] frame_cnt;
  logic              wrap;

  always_comb begin
    if (mode.tall)     last_com = CIDX_W'(TALL_ROWS - 1);
    else if (mode.two) last_com = CIDX_W'(2 * SHORT_ROWS - 1);
    else               last_com = CIDX_W'(SHORT_ROWS - 1);
  end

  assign wrap        = (com_idx == last_com);
  assign line_sel    = !mode.tall && (com_idx >= CIDX_W'(SHORT_ROWS));
  assign cell_row    = mode.tall ? ROW_W'(com_idx) : ROW_W'(com_idx[SROW_W-1:0]);
  assign last_row    = (cell_row == (mode.tall ? ROW_W'(TALL_ROWS - 1) : ROW_W'(SHORT_ROWS - 1)));
  assign blink_phase = frame_cnt[FCNT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_idx     <= '0;
      mode        <= '0;
      com_out     <= '0;
      frame_start <= 1'b0;
      frame_cnt   <= '0;
    end else begin
      frame_start <= 1'b0;
      if (row_start && (com_idx == '0)) begin
        mode.tall <= tall_i;
        mode.two  <= two_i;
      end
      if (row_done) begin
        com_out     <= NCOM'(1) << com_idx;
        frame_start <= wrap;
        if (wrap) begin
          com_idx   <= '0;
          frame_cnt <= frame_cnt + 1'b1;
        end else begin
          com_idx   <= com_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crow_overlay.sv
// Cursor and blink overlay on one fetched dot row.
module crow_overlay #(
  parameter int DOT_W = 5
) (
  input  logic [DOT_W-1:0] pat_i,
  input  logic             is_cur,
  input  logic             last_row,
  input  logic             cursor_en,
  input  logic             blink_en,
  input  logic             blink_phase,
  output logic [DOT_W-1:0] pat_o
);
  logic blank_on;
  logic under_on;

  assign blank_on = blink_en && blink_phase && is_cur;
  assign under_on = cursor_en && is_cur && last_row;

  always_comb begin
    if (blank_on)      pat_o = {DOT_W{1'b1}};
    else if (under_on) pat_o = {DOT_W{1'b1}};
    else               pat_o = pat_i;
  end
endmodule

// File: rtl/crow_shift.sv
// Serial segment shift register with a parallel output latch.
module crow_shift #(
  parameter int NSEG = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_i,
  input  logic            latch_en,
  output logic [NSEG-1:0] seg_out
);
  logic [NSEG-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      seg_out <= '0;
    end else begin
      if (shift_en) sr <= {sr[NSEG-2:0], bit_i};
      if (latch_en) seg_out <= sr;
    end
  end
endmodule

// File: rtl/crow_row_serializer.sv
module crow_row_serializer
  import crow_pkg::*;
#(
  parameter int          NSEG       = 40,
  parameter int          NCOM       = 16,
  parameter int          DOT_W      = 5,
  parameter int          CODE_W     = 8,
  parameter int          ADDR_W     = 7,
  parameter int          ROW_W      = 4,
  parameter int          CG_SEL_W   = 3,
  parameter int          LINE2_BASE = 64,
  parameter int          BLINK_LOG2 = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_slot,
  input  logic                         tall_font,
  input  logic                         two_line,
  input  logic                         cursor_en,
  input  logic                         blink_en,
  input  logic [ADDR_W-1:0]            ac,
  output logic                         dd_rd,
  output logic [ADDR_W-1:0]            dd_addr,
  input  logic [CODE_W-1:0]            dd_data,
  output logic                         cg_rd,
  output logic [CG_SEL_W+ROW_W-1:0]    cg_addr,
  input  logic [DOT_W-1:0]             cg_data,
  output logic                         rom_rd,
  output logic [CODE_W+ROW_W-1:0]      rom_addr,
  input  logic [DOT_W-1:0]             rom_data,
  output logic [NSEG-1:0]              seg_out,
  output logic [NCOM-1:0]              com_out,
  output logic                         latch_stb,
  output logic                         frame_start
);
  localparam int NCH   = NSEG / DOT_W;
  localparam int CH_W  = $clog2(NCH);
  localparam int BIT_W = $clog2(DOT_W);

  fetch_st_e           state;
  logic [CH_W-1:0]     char_k;
  logic [BIT_W-1:0]    bit_cnt;
  logic [CODE_W-1:0]   code_q;
  logic [DOT_W-1:0]    hold;

  mode_t               mode;
  logic [ROW_W-1:0]    cell_row;
  logic                line_sel;
  logic                last_row;
  logic                blink_phase;
  logic                row_start;
  logic                row_done;
  logic                shift_en;
  logic                use_cg;
  logic [CG_SEL_W-1:0] cg_sel;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DOT_W-1:0]    pat_raw;
  logic [DOT_W-1:0]    pat_ov;

  assign row_start = (state == ST_ROW);
  assign row_done  = (state == ST_LATCH);
  assign shift_en  = (state == ST_SHIFT);

  // position address: line base plus character index
  assign cur_addr = (line_sel ? ADDR_W'(LINE2_BASE) : '0) + ADDR_W'(char_k);
  assign dd_addr  = cur_addr;
  assign dd_rd    = (state == ST_DD_REQ) && !host_slot;

  // codes with an all-zero upper nibble select user glyphs
  assign use_cg   = (code_q[CODE_W-1:CG_SEL_W+1] == '0);
  assign cg_sel   = mode.tall ? {1'b0, code_q[CG_SEL_W-1:1]} : code_q[CG_SEL_W-1:0];
  assign cg_addr  = {cg_sel, cell_row};
  assign rom_addr = {code_q, cell_row};
  assign cg_rd    = (state == ST_PAT_REQ) && !host_slot && use_cg;
  assign rom_rd   = (state == ST_PAT_REQ) && !host_slot && !use_cg;
  assign pat_raw  = use_cg ? cg_data : rom_data;

  crow_seq #(
    .NCOM      (NCOM),
    .ROW_W     (ROW_W),
    .BLINK_LOG2(BLINK_LOG2)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_start  (row_start),
    .row_done   (row_done),
    .tall_i     (tall_font),
    .two_i      (two_line),
    .mode       (mode),
    .cell_row   (cell_row),
    .line_sel   (line_sel),
    .last_row   (last_row),
    .com_out    (com_out),
    .frame_start(frame_start),
    .blink_phase(blink_phase)
  );

  crow_overlay #(
    .DOT_W(DOT_W)
  ) ovl_i (
    .pat_i      (pat_raw),
    .is_cur     (cur_addr == ac),
    .last_row   (last_row),
    .cursor_en  (cursor_en),
    .blink_en   (blink_en),
    .blink_phase(blink_phase),
    .pat_o      (pat_ov)
  );

  crow_shift #(
    .NSEG(NSEG)
  ) shf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .bit_i   (hold[0]),
    .latch_en(row_done),
    .seg_out (seg_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ROW;
      char_k    <= '0;
      bit_cnt   <= '0;
      code_q    <= '0;
      hold      <= '0;
      latch_stb <= 1'b0;
    end else begin
      latch_stb <= (state == ST_LATCH);
      case (state)
        ST_ROW: begin
          char_k <= CH_W'(NCH - 1);
          state  <= ST_DD_REQ;
        end
        ST_DD_REQ:  if (!host_slot) state <= ST_DD_WAIT;
        ST_DD_WAIT: begin
          code_q <= dd_data;
          state  <= ST_PAT_REQ;
        end
        ST_PAT_REQ: if (!host_slot) state <= ST_PAT_WAIT;
        ST_PAT_WAIT: begin
          hold    <= pat_ov;
          bit_cnt <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          hold <= hold >> 1;
          if (bit_cnt == BIT_W'(DOT_W - 1)) begin
            bit_cnt <= '0;
            if (char_k == '0) begin
              state <= ST_LATCH;
            end else begin
              char_k <= char_k - 1'b1;
              state  <= ST_DD_REQ;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_LATCH: state <= ST_ROW;
        default:  state <= ST_ROW;
      endcase
    end
  end
endmodule

// File: rtl/crow_chk.sv
module crow_chk #(
  parameter int NSEG  = 40,
  parameter int NCOM  = 16,
  parameter int CGA_W = 7,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_slot,
  input logic             dd_rd,
  input logic             cg_rd,
  input logic             rom_rd,
  input logic [CGA_W-1:0] cg_addr,
  input logic [NSEG-1:0]  seg_out,
  input logic [NCOM-1:0]  com_out,
  input logic             latch_stb,
  input logic             frame_start
);
  // R11
  no_read_in_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_slot |-> !(dd_rd || cg_rd || rom_rd));

  // R13
  single_pattern_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cg_rd && rom_rd));

  // R9
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_out));

  // R9
  com_set_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> ($countones(com_out) == 1));

  // R9
  com_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |-> $stable(com_out));

  // R3
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |-> $stable(seg_out));

  // R10
  frame_with_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> latch_stb);

  // R5
  cg_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_rd |-> (cg_addr[ROW_W-1:0] <= ROW_W'(10)));
endmodule

bind crow_row_serializer crow_chk #(
  .NSEG (NSEG),
  .NCOM (NCOM),
  .CGA_W(CG_SEL_W + ROW_W),
  .ROW_W(ROW_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_slot  (host_slot),
  .dd_rd      (dd_rd),
  .cg_rd      (cg_rd),
  .rom_rd     (rom_rd),
  .cg_addr    (cg_addr),
  .seg_out    (seg_out),
  .com_out    (com_out),
  .latch_stb  (latch_stb),
  .frame_start(frame_start)
);

// File: tb/crow_row_serializer_tb_top.sv
module crow_row_serializer_tb_top;
  localparam int BL = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_slot = 1'b0;
  logic        tall_font = 1'b0;
  logic        two_line = 1'b0;
  logic        cursor_en = 1'b0;
  logic        blink_en = 1'b0;
  logic [6:0]  ac = '0;
  logic        dd_rd, cg_rd, rom_rd;
  logic [6:0]  dd_addr, cg_addr;
  logic [11:0] rom_addr;
  logic [7:0]  dd_data;
  logic [4:0]  cg_data, rom_data;
  logic [39:0] seg_out;
  logic [15:0] com_out;
  logic        latch_stb, frame_start;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] dd_mem [128];
  logic [4:0] cg_mem [128];
  bit m_tall, m_two;
  int exp_com = 0;
  int frame_no = 0;
  int viol = 0;
  int dual = 0;

  always #10 clk = ~clk;

  function automatic logic [4:0] rom_fn(input logic [7:0] c, input logic [3:0] r);
    return 5'((c * 3) ^ (r * 7) ^ (c >> 4) ^ 5'h0B);
  endfunction

  always @(posedge clk) begin
    dd_data  <= dd_mem[dd_addr];
    cg_data  <= cg_mem[cg_addr];
    rom_data <= rom_fn(rom_addr[11:4], rom_addr[3:0]);
  end

  crow_row_serializer #(.BLINK_LOG2(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_slot(host_slot), .tall_font(tall_font),
    .two_line(two_line), .cursor_en(cursor_en), .blink_en(blink_en), .ac(ac),
    .dd_rd(dd_rd), .dd_addr(dd_addr), .dd_data(dd_data),
    .cg_rd(cg_rd), .cg_addr(cg_addr), .cg_data(cg_data),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .seg_out(seg_out), .com_out(com_out), .latch_stb(latch_stb),
    .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int lastc();
    return m_tall ? 10 : (m_two ? 15 : 7);
  endfunction

  // expected latched row for common c, from the requirement text
  function automatic logic [39:0] exp_row(input int c);
    logic [39:0] r;
    int row, lastr, base;
    logic [7:0] code;
    logic [6:0] a;
    logic [2:0] sel;
    logic [4:0] pat;
    r = '0;
    row   = m_tall ? c : c % 8;
    lastr = m_tall ? 10 : 7;
    base  = (!m_tall && c >= 8) ? 64 : 0;
    for (int p = 0; p < 8; p++) begin
      a = 7'(base + p);
      code = dd_mem[a];
      if (code[7:4] == 4'd0) begin
        sel = m_tall ? {1'b0, code[2:1]} : code[2:0];
        pat = cg_mem[{sel, 4'(row)}];
      end else begin
        pat = rom_fn(code, 4'(row));
      end
      if (a == ac) begin
        if (blink_en && (((frame_no >> BL) & 1) == 1)) pat = 5'h1F;
        else if (cursor_en && row == lastr) pat = 5'h1F;
      end
      for (int d = 0; d < 5; d++) r[5*p+d] = pat[4-d];
    end
    return r;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 128; i++) begin
      dd_mem[i] = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
      cg_mem[i] = 5'($urandom);
    end
  endtask

  task automatic cap();
    m_tall = tall_font;
    m_two  = two_line;
  endtask

  task automatic run_frames(input int nf, input string tag, input bit flip, input bit alias_chk);
    int seen;
    int lat;
    logic [39:0] e;
    seen = 0;
    lat = 0;
    while (seen < nf) begin
      @(negedge clk);
      if (latch_stb) begin
        e = exp_row(exp_com);
        chk(seg_out === e, tag, 64'(seg_out), 64'(e));
        chk(com_out === (16'd1 << exp_com), "R9 common select", 64'(com_out), 64'(16'd1 << exp_com));
        chk(frame_start === (exp_com == lastc()), "R10 frame start pulse",
            64'(frame_start), 64'(exp_com == lastc()));
        if (alias_chk)
          chk((seg_out[4:0] === seg_out[9:5]) && (seg_out[9:5] === seg_out[14:10]) &&
              (seg_out[14:10] === seg_out[19:15]), "R5 codes 00/01/08/09 alias",
              64'(seg_out[19:0]), {44'd0, {4{seg_out[4:0]}}});
        lat++;
        if (flip && lat == 3) two_line = ~two_line;
        if (exp_com == lastc()) begin
          exp_com = 0;
          frame_no++;
          seen++;
          cap();
        end else begin
          exp_com++;
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3;
      host_slot = (($urandom % 4) == 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && host_slot && (dd_rd || cg_rd || rom_rd)) viol++;
      if (rst_n && cg_rd && rom_rd) dual++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd77));
    fill_mem();
    tall_font = 1'b0; two_line = 1'b0; cursor_en = 1'b1; blink_en = 1'b0; ac = 7'd3;
    cap();
    repeat (3) @(negedge clk);
    chk(seg_out === '0, "R1 reset segments", 64'(seg_out), 64'd0);
    chk(com_out === '0, "R1 reset commons", 64'(com_out), 64'd0);
    chk(latch_stb === 1'b0, "R1 reset latch strobe", 64'(latch_stb), 64'd0);
    chk(frame_start === 1'b0, "R1 reset frame start", 64'(frame_start), 64'd0);
    rst_n = 1'b1;

    // one line, short font, cursor at position 3
    run_frames(2, "R2/R3/R4 one-line rows", 1'b0, 1'b0);

    // two lines, cursor on second text line
    fill_mem();
    two_line = 1'b1; ac = 7'h45; cursor_en = 1'b1;
    cap();
    run_frames(2, "R7 cursor two-line rows", 1'b0, 1'b0);

    // tall font, aliased user codes, row-10 OR term, cursor off
    fill_mem();
    tall_font = 1'b1; two_line = 1'b0; cursor_en = 1'b0; ac = 7'h20;
    dd_mem[0] = 8'h00; dd_mem[1] = 8'h01; dd_mem[2] = 8'h08; dd_mem[3] = 8'h09;
    cg_mem[{3'd0, 4'd10}] = 5'b10101;
    cap();
    run_frames(2, "R6 tall-font rows", 1'b0, 1'b1);

    // blink over four frames to see both phases
    fill_mem();
    tall_font = 1'b0; two_line = 1'b1; blink_en = 1'b1; cursor_en = 1'b0; ac = 7'd2;
    cap();
    run_frames(4, "R8 blink rows", 1'b0, 1'b0);

    // mode change in mid-frame takes effect next frame
    fill_mem();
    blink_en = 1'b0; two_line = 1'b0; cursor_en = 1'b1; ac = 7'd6;
    cap();
    run_frames(2, "R12 mode sampled per frame", 1'b1, 1'b0);

    // random configurations
    for (int i = 0; i < 4; i++) begin
      fill_mem();
      tall_font = 1'($urandom);
      two_line  = 1'($urandom);
      cursor_en = 1'($urandom);
      blink_en  = 1'($urandom);
      ac = ($urandom % 2) ? 7'($urandom % 8) : 7'(64 + $urandom % 8);
      cap();
      run_frames(1, "R2/R4/R7/R8 random rows", 1'b0, 1'b0);
    end

    chk(viol == 0, "R11 display read during host slot", 64'(viol), 64'd0);
    chk(dual == 0, "R13 both pattern ports strobed", 64'(dual), 64'd0);
    finish_run();
  end
endmodule